// File: doc/BRIEF.md
# Oversampling Serial Bit Sampler

This block turns an asynchronous serial line into one decided value per bit period. An external baud generator supplies a tick at 16 or 8 times the bit rate. A 4-bit counter counts these ticks and finds the middle of each bit period. The block keeps the samples around that middle point. At the last sample of the period it emits the decided bit value together with a one-cycle valid strobe.

Two run-time mode bits control the block. One sets the ratio to 16 or 8 samples per bit. The other sets how the level is decided. In majority mode the block votes over three centre samples, and any disagreement among them sets a noise flag. In single-sample mode the block takes one centre sample and never reports noise. An alignment pulse from the surrounding receiver starts a new frame: it clears the counter and the noise flag, and it loads the mode bits. A mode change therefore never lands in the middle of a bit. Start-bit search, frame assembly and parity belong to other blocks.

Top module: `uart_bit_sampler`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `bit_valid` is 0, `noise` is 0 and `bit_out` is 1. The mode register resets to 16 samples per bit with majority decisions.
- R2: With `cfg_os8`=0 a bit period lasts 16 ticks, and with `cfg_os8`=1 it lasts 8. `bit_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the final tick of the period. It is low at all other times.
- R3: The sample counter moves only on a clock edge where `os_tick` is 1. `align` resets the counter, so any partial bit already counted is dropped. When `align` and `os_tick` are both high on the same edge, `align` wins and the tick is not counted.
- R4: Majority mode (`cfg_single`=0) numbers the ticks of a period from 1. It votes the line at ticks 8, 9 and 10 in 16x mode, and at ticks 4, 5 and 6 in 8x mode. `bit_out` is the majority of those three samples. The line value at every other tick has no effect.
- R5: Single-sample mode (`cfg_single`=1) sets `bit_out` to the line value at tick 9 in 16x mode, or tick 5 in 8x mode. In this mode `noise` never goes high.
- R6: In majority mode, if the three voted samples are not all equal, `noise` rises in the same cycle as `bit_valid` and never earlier. It then stays high for later bits of the frame, even when those bits are clean.
- R7: An `align` pulse clears `noise` to 0 by the next cycle.
- R8: `cfg_os8` and `cfg_single` are loaded only on an edge where `align` is high. Changing them during a frame has no effect on that frame.
- R9: `bit_out` keeps its value between strobes and changes only in a cycle where `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronized serial line |
| os_tick | input | 1 | Oversampling tick, one cycle wide |
| align | input | 1 | Start-of-frame alignment; loads the modes, clears the counter and noise |
| cfg_os8 | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| cfg_single | input | 1 | 0: majority of three samples, 1: one centre sample |
| bit_out | output | 1 | Decided bit value |
| bit_valid | output | 1 | One-cycle strobe marking a new decision |
| noise | output | 1 | Sticky noise flag for the current frame |

## Verification
The bench runs every one of the eight patterns of the three centre samples under all four mode combinations. All ticks outside the centre carry the inverse of the expected result. A sampler that votes the wrong indices, or that is off by one in its counter, therefore decides the wrong value, and a wrong ratio moves the strobe to a different tick. The mode inputs are flipped right after each alignment, so a design that reads them live samples at the wrong ratio. Some frames start with stray ticks before alignment, and some place a tick in the same cycle as `align`; a design that keeps the partial count, or lets the tick through, strobes early. A noisy bit followed by a clean bit shows whether noise is sticky, and checks one tick before the strobe show whether it rises too early.

// File: rtl/uart_bit_sampler.sv
module uart_bit_sampler #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic os_tick,
  input  logic align,
  input  logic cfg_os8,
  input  logic cfg_single,
  output logic bit_out,
  output logic bit_valid,
  output logic noise
);
  localparam int IW = CNT_W + 1;
  localparam logic [IW-1:0] FULL = IW'(1 << CNT_W);
  localparam logic [IW-1:0] HALF = IW'(1 << (CNT_W - 1));
  localparam logic [IW-1:0] ONE  = IW'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             os8_q, single_q;
  logic [2:0]       smp_q;

  logic [IW-1:0] idx, ratio, mid;
  logic          last, vote, split;

  assign idx   = {1'b0, cnt_q} + ONE;
  assign ratio = os8_q ? HALF : FULL;
  assign mid   = (ratio >> 1) + ONE;
  assign last  = (idx == ratio);
  assign vote  = (smp_q[0] & smp_q[1]) | (smp_q[1] & smp_q[2]) | (smp_q[0] & smp_q[2]);
  assign split = (|smp_q) & ~(&smp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      os8_q     <= 1'b0;
      single_q  <= 1'b0;
      smp_q     <= '0;
      bit_out   <= 1'b1;
      bit_valid <= 1'b0;
      noise     <= 1'b0;
    end else if (align) begin
      cnt_q     <= '0;
      os8_q     <= cfg_os8;
      single_q  <= cfg_single;
      bit_valid <= 1'b0;
      noise     <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (os_tick) begin
        if (idx == mid - ONE) smp_q[0] <= line_in;
        if (idx == mid)       smp_q[1] <= line_in;
        if (idx == mid + ONE) smp_q[2] <= line_in;
        if (last) begin
          cnt_q     <= '0;
          bit_valid <= 1'b1;
          bit_out   <= single_q ? smp_q[1] : vote;
          if (!single_q && split) noise <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_bit_sampler_chk.sv
module uart_bit_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic align,
  input logic single_q,
  input logic bit_out,
  input logic bit_valid,
  input logic noise
);
  assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_strobe_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(os_tick) && !$past(align)));

  assert_noise_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise) |-> bit_valid);

  assert_noise_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> !noise);

  assert_single_no_noise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (single_q && !noise && !align) |=> !noise);

  assert_out_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> $stable(bit_out));
endmodule

bind uart_bit_sampler uart_bit_sampler_chk i_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .align(align),
  .single_q(single_q), .bit_out(bit_out), .bit_valid(bit_valid), .noise(noise)
);

// File: tb/test_uart_bit_sampler.sv
module test_uart_bit_sampler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1, os_tick = 1'b0, align = 1'b0, cfg_os8 = 1'b0, cfg_single = 1'b0;
  logic bit_out, bit_valid, noise;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_bit_sampler i_uart_bit_sampler (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .os_tick(os_tick), .align(align),
    .cfg_os8(cfg_os8), .cfg_single(cfg_single),
    .bit_out(bit_out), .bit_valid(bit_valid), .noise(noise)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_align(input bit os8, input bit single, input bit with_tick);
    cfg_os8 = os8; cfg_single = single; align = 1'b1; os_tick = with_tick; line_in = 1'b0;
    @(negedge clk);
    align = 1'b0; os_tick = 1'b0;
    chk("R7 noise after align", noise, 0);
    cfg_os8 = ~os8; cfg_single = ~single;
  endtask

  task automatic do_bit(input bit os8, input bit single, input logic [2:0] pat, input bit prior);
    int ratio, mid;
    bit maj, exp_out, exp_noise, v;
    ratio = os8 ? 8 : 16;
    mid = ratio / 2 + 1;
    maj = (pat[0] & pat[1]) | (pat[1] & pat[2]) | (pat[0] & pat[2]);
    exp_out = single ? pat[1] : maj;
    exp_noise = prior | (!single && pat != 3'b000 && pat != 3'b111);
    for (int i = 1; i <= ratio; i++) begin
      if (i == mid - 1) v = pat[0];
      else if (i == mid) v = pat[1];
      else if (i == mid + 1) v = pat[2];
      else v = ~exp_out;
      line_in = v; os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
      if (i < ratio) begin
        if (bit_valid) chk("R2 early strobe", bit_valid, 0);
        if (i == ratio - 1) chk("R6 noise before strobe", noise, int'(prior));
      end else begin
        chk("R2 strobe at final tick", bit_valid, 1);
        chk(single ? "R5 single value" : "R4 majority value", bit_out, int'(exp_out));
        chk(single ? "R5 no noise" : "R6 noise", noise, int'(exp_noise));
      end
      @(negedge clk);
      if (i == ratio) begin
        chk("R2 strobe one cycle", bit_valid, 0);
        chk("R9 value held", bit_out, int'(exp_out));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", bit_valid, 0);
    chk("R1 reset noise", noise, 0);
    chk("R1 reset out", bit_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release out", bit_out, 1);
    // R8: default mode is 16x majority without any align
    do_bit(1'b0, 1'b0, 3'b110, 1'b0);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        if (p[0]) begin
          for (int k = 0; k < 3; k++) begin
            line_in = 1'b0; os_tick = 1'b1; @(negedge clk); os_tick = 1'b0; @(negedge clk);
          end
        end
        do_align(m[1], m[0], p[1]);   // R3 stray ticks and align+tick, R8 cfg flipped
        do_bit(m[1], m[0], 3'(p), 1'b0);
      end
    end
    do_align(1'b0, 1'b0, 1'b0);
    do_bit(1'b0, 1'b0, 3'b010, 1'b0);
    do_bit(1'b0, 1'b0, 3'b111, 1'b1);  // R6 sticky
    do_bit(1'b0, 1'b0, 3'b000, 1'b1);
    do_align(1'b1, 1'b0, 1'b0);        // R7 clears
    do_bit(1'b1, 1'b0, 3'b101, 1'b0);
    do_align(1'b1, 1'b1, 1'b0);
    do_bit(1'b1, 1'b1, 3'b010, 1'b0);  // R5 disagreement without noise
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule